// File: doc/BRIEF.md
# Descriptor-driven interrupt transfer engine

The engine takes over peripheral interrupt requests and answers each one by moving a single data item between a peripheral register and a memory buffer, so no software copy routine has to run. Each channel has a pointer input that gives the byte address of a four-word transfer descriptor in RAM. For every accepted request the engine reads the descriptor over its own memory-bus master port, performs one read and one write for the data item, writes the updated I/O address, count and buffer address back, and releases the bus. No CPU register is involved at any point, so nothing has to be saved or restored around a transfer.

The service ends either when the remaining count reaches zero or when the peripheral raises a terminate request. In both cases the end reason is first written into the status field of the descriptor mode word, and only after that write has been acknowledged does the engine pulse the channel's normal interrupt output, so the handler always finds the reason in memory. A channel whose service is disabled passes its request straight to the interrupt output instead.

Top module: `isr_xfer_engine`

## Requirements
- R1: The descriptor of channel c sits at the byte address on that channel's pointer input and holds four 16-bit little-endian words: mode at +0, I/O address at +2, remaining count at +4, buffer address at +6.
- R2: Mode word bits: bit 2 selects direction (0 I/O register to buffer, 1 buffer to I/O register), bit 3 selects width (0 one byte on the low lane, 1 a 16-bit word); a byte transfer changes exactly one memory byte.
- R3: With mode bit 0 set the buffer address advances by the transfer size (1 for byte, 2 for word) after each transfer; with it clear the address stays fixed.
- R4: With mode bit 1 set the I/O address advances by the transfer size after each transfer; with it clear the address stays fixed.
- R5: A terminate request on an enabled channel is held until served; that service moves no data, leaves count and addresses unchanged, writes status 10 into mode bits 5:4 and pulses the channel interrupt.
- R6: After each transfer the count is decremented and written back; when it reaches zero status 01 is written into mode bits 5:4, and the interrupt pulses only after that write; non-final transfers raise no interrupt.
- R7: A descriptor whose count is already zero when fetched causes no data transfer, status 01 is written and the interrupt pulses.
- R8: A request on a channel whose service enable is low performs no bus access and pulses that channel's interrupt output one cycle later.
- R9: When several channels have pending work, the lowest-numbered channel is served first.
- R10: After reset there is no bus request, all interrupt outputs are low and the busy output is low.
- R11: A bus request keeps address, write flag and write data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| svc_en_i | input | NUM_CH | Per-channel service enable |
| desc_ptr_i | input | NUM_CH*AW | Per-channel descriptor byte address, channel c in bits c*AW upward |
| req_i | input | NUM_CH | Peripheral request pulses |
| term_i | input | NUM_CH | Peripheral terminate pulses |
| irq_o | output | NUM_CH | One-cycle interrupt pulses to the CPU |
| busy_o | output | 1 | Work pending or in progress |
| mem_req_o | output | 1 | Bus request, held until acknowledge |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_word_o | output | 1 | 16-bit access when high, byte on low lane when low |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access complete |

## Verification
The bench builds the engine with four channels, 16-bit addresses and 16-bit data, so byte and word lanes, both directions, fixed and advancing addresses, and priority between channels that are not adjacent all come within reach. A slave model with one wait cycle per access holds requests across a non-acknowledged cycle, which exposes any drift on the bus. The end paths (count exhausted after transfers, count zero on fetch, peripheral terminate) and the disabled-channel bypass are each driven on their own channel while an every-clock monitor rejects any interrupt the bench did not expect.

// File: rtl/isr_xfer_pkg.sv
package isr_xfer_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RD_MODE, S_RD_IO, S_RD_CNT, S_RD_BUF,
    S_XF_RD, S_XF_WR, S_WB_IO, S_WB_CNT, S_WB_BUF, S_WB_MODE
  } xfer_st_e;

  localparam int MB_BUF_INC = 0;
  localparam int MB_IO_INC  = 1;
  localparam int MB_DIR     = 2;
  localparam int MB_WORD    = 3;
  localparam int MB_ST_LO   = 4;
  localparam int MB_ST_HI   = 5;

  localparam logic [1:0] END_ACTIVE = 2'b00;
  localparam logic [1:0] END_COUNT  = 2'b01;
  localparam logic [1:0] END_TERM   = 2'b10;
endpackage

// File: rtl/isr_xfer_pend.sv
module isr_xfer_pend #(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] term_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] pend_req_o,
  output logic [NUM_CH-1:0] pend_term_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_req_o[g]  <= 1'b0;
        pend_term_o[g] <= 1'b0;
      end else begin
        // new arrivals win over a clear in the same cycle
        pend_req_o[g]  <= (pend_req_o[g] & ~clr_i[g]) | (req_i[g] & en_i[g]);
        pend_term_o[g] <= (pend_term_o[g] & ~clr_i[g]) | (term_i[g] & en_i[g]);
      end
    end
  end
endmodule

// File: rtl/isr_xfer_arb.sv
module isr_xfer_arb #(
  parameter int NUM_CH = 4,
  localparam int CW = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] pend_i,
  output logic [NUM_CH-1:0] gnt_o,
  output logic [CW-1:0]     idx_o,
  output logic              any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (pend_i[i] && !any_o) begin
        gnt_o[i] = 1'b1;
        idx_o    = CW'(i);
        any_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/isr_xfer_ctrl.sv
module isr_xfer_ctrl
  import isr_xfer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AW     = 16,
  parameter int DW     = 16,
  localparam int CW    = $clog2(NUM_CH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] sel_idx_i,
  input  logic [AW-1:0] sel_ptr_i,
  input  logic          sel_term_i,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic          end_o,
  output logic [CW-1:0] end_idx_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic          mem_word_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o
);
  localparam int BYTES = DW / 8;
  localparam logic [AW-1:0] OFS_IO  = AW'(BYTES);
  localparam logic [AW-1:0] OFS_CNT = AW'(2 * BYTES);
  localparam logic [AW-1:0] OFS_BUF = AW'(3 * BYTES);

  xfer_st_e      st_q;
  logic [CW-1:0] ch_q;
  logic [AW-1:0] ptr_q, io_q, buf_q;
  logic [DW-1:0] mode_q, cnt_q, data_q;
  logic          term_q;
  logic [1:0]    code_q;
  logic [AW-1:0] step;
  logic [DW-1:0] mode_out;
  logic          dir_mem2io;

  assign step       = mode_q[MB_WORD] ? AW'(BYTES) : AW'(1);
  assign dir_mem2io = mode_q[MB_DIR];
  assign busy_o     = (st_q != S_IDLE);
  assign mem_req_o  = busy_o;
  assign accept_o   = (st_q == S_IDLE) && start_i;
  assign end_o      = (st_q == S_WB_MODE) && mem_ack_i;
  assign end_idx_o  = ch_q;

  always_comb begin
    mode_out = mode_q;
    mode_out[MB_ST_HI:MB_ST_LO] = code_q;
  end

  always_comb begin
    mem_we_o    = 1'b0;
    mem_word_o  = 1'b1;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (st_q)
      S_RD_MODE: mem_addr_o = ptr_q;
      S_RD_IO:   mem_addr_o = ptr_q + OFS_IO;
      S_RD_CNT:  mem_addr_o = ptr_q + OFS_CNT;
      S_RD_BUF:  mem_addr_o = ptr_q + OFS_BUF;
      S_XF_RD: begin
        mem_addr_o = dir_mem2io ? buf_q : io_q;
        mem_word_o = mode_q[MB_WORD];
      end
      S_XF_WR: begin
        mem_addr_o  = dir_mem2io ? io_q : buf_q;
        mem_word_o  = mode_q[MB_WORD];
        mem_we_o    = 1'b1;
        mem_wdata_o = data_q;
      end
      S_WB_IO: begin
        mem_addr_o  = ptr_q + OFS_IO;
        mem_we_o    = 1'b1;
        mem_wdata_o = DW'(io_q);
      end
      S_WB_CNT: begin
        mem_addr_o  = ptr_q + OFS_CNT;
        mem_we_o    = 1'b1;
        mem_wdata_o = cnt_q;
      end
      S_WB_BUF: begin
        mem_addr_o  = ptr_q + OFS_BUF;
        mem_we_o    = 1'b1;
        mem_wdata_o = DW'(buf_q);
      end
      S_WB_MODE: begin
        mem_addr_o  = ptr_q;
        mem_we_o    = 1'b1;
        mem_wdata_o = mode_out;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      ch_q   <= '0;
      ptr_q  <= '0;
      io_q   <= '0;
      buf_q  <= '0;
      mode_q <= '0;
      cnt_q  <= '0;
      data_q <= '0;
      term_q <= 1'b0;
      code_q <= END_ACTIVE;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          ch_q   <= sel_idx_i;
          ptr_q  <= sel_ptr_i;
          term_q <= sel_term_i;
          code_q <= END_ACTIVE;
          st_q   <= S_RD_MODE;
        end
        S_RD_MODE: if (mem_ack_i) begin
          mode_q <= mem_rdata_i;
          if (term_q) begin
            code_q <= END_TERM;
            st_q   <= S_WB_MODE;
          end else begin
            st_q <= S_RD_IO;
          end
        end
        S_RD_IO: if (mem_ack_i) begin
          io_q <= AW'(mem_rdata_i);
          st_q <= S_RD_CNT;
        end
        S_RD_CNT: if (mem_ack_i) begin
          cnt_q <= mem_rdata_i;
          if (mem_rdata_i == '0) begin
            code_q <= END_COUNT;
            st_q   <= S_WB_MODE;
          end else begin
            st_q <= S_RD_BUF;
          end
        end
        S_RD_BUF: if (mem_ack_i) begin
          buf_q <= AW'(mem_rdata_i);
          st_q  <= S_XF_RD;
        end
        S_XF_RD: if (mem_ack_i) begin
          data_q <= mode_q[MB_WORD] ? mem_rdata_i : DW'(mem_rdata_i[7:0]);
          st_q   <= S_XF_WR;
        end
        S_XF_WR: if (mem_ack_i) begin
          if (mode_q[MB_IO_INC])  io_q  <= io_q + step;
          if (mode_q[MB_BUF_INC]) buf_q <= buf_q + step;
          cnt_q <= cnt_q - DW'(1);
          st_q  <= S_WB_IO;
        end
        S_WB_IO:  if (mem_ack_i) st_q <= S_WB_CNT;
        S_WB_CNT: if (mem_ack_i) st_q <= S_WB_BUF;
        S_WB_BUF: if (mem_ack_i) begin
          if (cnt_q == '0) begin
            code_q <= END_COUNT;
            st_q   <= S_WB_MODE;
          end else begin
            st_q <= S_IDLE;
          end
        end
        S_WB_MODE: if (mem_ack_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/isr_xfer_engine.sv
module isr_xfer_engine #(
  parameter int NUM_CH = 4,
  parameter int AW     = 16,
  parameter int DW     = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CH-1:0]    svc_en_i,
  input  logic [NUM_CH*AW-1:0] desc_ptr_i,
  input  logic [NUM_CH-1:0]    req_i,
  input  logic [NUM_CH-1:0]    term_i,
  output logic [NUM_CH-1:0]    irq_o,
  output logic                 busy_o,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic                 mem_word_o,
  output logic [AW-1:0]        mem_addr_o,
  output logic [DW-1:0]        mem_wdata_o,
  input  logic [DW-1:0]        mem_rdata_i,
  input  logic                 mem_ack_i
);
  localparam int CW = $clog2(NUM_CH);

  logic [NUM_CH-1:0] pend_req, pend_term, gnt, clr, end_vec;
  logic [CW-1:0]     sel_idx, end_idx;
  logic              any_pend, accept, ctrl_busy, ctrl_end;
  logic [AW-1:0]     ptr_arr [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_map
    assign ptr_arr[g] = desc_ptr_i[g*AW +: AW];
    assign end_vec[g] = ctrl_end && (end_idx == CW'(g));
  end

  assign clr = gnt & {NUM_CH{accept}};

  isr_xfer_pend #(.NUM_CH(NUM_CH)) pend_i (
    .clk_i, .rst_ni,
    .en_i        (svc_en_i),
    .req_i       (req_i),
    .term_i      (term_i),
    .clr_i       (clr),
    .pend_req_o  (pend_req),
    .pend_term_o (pend_term)
  );

  isr_xfer_arb #(.NUM_CH(NUM_CH)) arb_i (
    .pend_i (pend_req | pend_term),
    .gnt_o  (gnt),
    .idx_o  (sel_idx),
    .any_o  (any_pend)
  );

  isr_xfer_ctrl #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW)) ctrl_i (
    .clk_i, .rst_ni,
    .start_i     (any_pend),
    .sel_idx_i   (sel_idx),
    .sel_ptr_i   (ptr_arr[sel_idx]),
    .sel_term_i  (pend_term[sel_idx]),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .accept_o    (accept),
    .busy_o      (ctrl_busy),
    .end_o       (ctrl_end),
    .end_idx_o   (end_idx),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_word_o  (mem_word_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= '0;
    else         irq_o <= (req_i & ~svc_en_i) | end_vec;
  end

  assign busy_o = ctrl_busy | any_pend;
endmodule

// File: rtl/isr_xfer_engine_chk.sv
module isr_xfer_engine_chk #(
  parameter int NUM_CH = 4,
  parameter int AW     = 16,
  parameter int DW     = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] svc_en_i,
  input logic [NUM_CH-1:0] req_i,
  input logic [NUM_CH-1:0] irq_o,
  input logic [NUM_CH-1:0] end_vec,
  input logic [NUM_CH-1:0] gnt,
  input logic              ctrl_end,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_ack_i,
  input logic [AW-1:0]     mem_addr_o,
  input logic [DW-1:0]     mem_wdata_o
);
  AST_BUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)); // R11

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt)); // R9

  AST_END_ON_STATUS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_end |-> mem_req_o && mem_ack_i && mem_we_o && (mem_wdata_o[5:4] != 2'b00)); // R6

  AST_IRQ_ONLY_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & $past(svc_en_i) & ~$past(end_vec)) == '0); // R6

  AST_DISABLED_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_i & ~svc_en_i) != '0) |=> ((irq_o & $past(req_i & ~svc_en_i)) == $past(req_i & ~svc_en_i))); // R8
endmodule

bind isr_xfer_engine isr_xfer_engine_chk #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW)) chk_i (.*);

// File: tb/isr_xfer_engine_tb_top.sv
module isr_xfer_engine_tb_top;
  localparam int NCH = 4;
  localparam int AW  = 16;
  localparam int DW  = 16;

  logic clk_i = 1'b0;
  always #10 clk_i = ~clk_i;

  logic              rst_ni;
  logic [NCH-1:0]    svc_en, req, term, irq;
  logic [NCH*AW-1:0] desc_ptr;
  logic              busy, mem_req, mem_we, mem_word, mem_ack;
  logic [AW-1:0]     mem_addr;
  logic [DW-1:0]     mem_wdata, mem_rdata;

  isr_xfer_engine #(.NUM_CH(NCH), .AW(AW), .DW(DW)) dut_i (
    .clk_i, .rst_ni,
    .svc_en_i(svc_en), .desc_ptr_i(desc_ptr), .req_i(req), .term_i(term),
    .irq_o(irq), .busy_o(busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_word_o(mem_word),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  // memory slave, one wait cycle per access; bench pokes go through it too
  logic [7:0]  mem [0:4095];
  logic [11:0] ma, ma1;
  logic        pk_en = 1'b0;
  logic [11:0] pk_addr = '0;
  logic [15:0] pk_data = '0;
  assign ma  = mem_addr[11:0];
  assign ma1 = ma + 12'd1;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) begin
          mem[ma] <= mem_wdata[7:0];
          if (mem_word) mem[ma1] <= mem_wdata[15:8];
        end else begin
          mem_rdata <= mem_word ? {mem[ma1], mem[ma]} : {8'h00, mem[ma]};
        end
      end else if (pk_en) begin
        mem[pk_addr]         <= pk_data[7:0];
        mem[pk_addr + 12'd1] <= pk_data[15:8];
      end
    end
  end

  // every-clock monitor: interrupts must be expected, bus must hold
  int             irq_cnt [NCH];
  int             order_q [$];
  int             mon_fail = 0;
  logic [NCH-1:0] allow = '0;
  logic           prev_hold = 1'b0;
  logic [AW-1:0]  prev_addr = '0;
  initial for (int i = 0; i < NCH; i++) irq_cnt[i] = 0;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      for (int c = 0; c < NCH; c++) begin
        if (irq[c]) begin
          irq_cnt[c] = irq_cnt[c] + 1;
          order_q.push_back(c);
          if (!allow[c]) begin
            mon_fail = mon_fail + 1;
            $display("FAIL R6 unexpected irq ch%0d act=1 exp=0", c);
          end
        end
      end
      if (prev_hold && (!mem_req || mem_addr != prev_addr)) begin
        mon_fail = mon_fail + 1;
        $display("FAIL R11 bus moved act=%0h exp=%0h", mem_addr, prev_addr);
      end
      prev_hold = mem_req && !mem_ack;
      prev_addr = mem_addr;
    end
  end

  int nchk = 0;
  int nfail = 0;

  initial begin
    repeat (100000) @(posedge clk_i);
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk + 1, nfail + 1);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic poke16(input int a, input logic [15:0] d);
    @(negedge clk_i);
    pk_en = 1'b1; pk_addr = 12'(a); pk_data = d;
    @(negedge clk_i);
    pk_en = 1'b0;
  endtask

  function automatic logic [15:0] peek16(input int a);
    return {mem[12'(a + 1)], mem[12'(a)]};
  endfunction

  function automatic int dp(input int c);
    return 32'h200 + c * 32'h10;
  endfunction

  task automatic set_desc(input int c, input logic [15:0] md, input logic [15:0] io,
                          input logic [15:0] cnt, input logic [15:0] bf);
    poke16(dp(c), md); poke16(dp(c) + 2, io); poke16(dp(c) + 4, cnt); poke16(dp(c) + 6, bf);
  endtask

  task automatic fire(input logic [NCH-1:0] rm, input logic [NCH-1:0] tm);
    @(negedge clk_i);
    req = rm; term = tm;
    @(negedge clk_i);
    req = '0; term = '0;
    repeat (2) @(negedge clk_i);
    while (busy) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  function automatic logic [1:0] status(input int c);
    logic [15:0] w;
    w = peek16(dp(c));
    return w[5:4];
  endfunction

  initial begin
    int base;
    rst_ni = 1'b0; svc_en = '1; req = '0; term = '0;
    for (int c = 0; c < NCH; c++) desc_ptr[c*AW +: AW] = AW'(dp(c));
    repeat (3) @(negedge clk_i);
    chk("R10 irq after reset", 32'(irq), 0);
    chk("R10 mem_req after reset", 32'(mem_req), 0);
    chk("R10 busy after reset", 32'(busy), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // ch0: word, I/O to buffer, buffer advances, count 3
    set_desc(0, 16'h0009, 16'h0100, 16'd3, 16'h0400);
    for (int k = 0; k < 3; k++) begin
      poke16(32'h100, 16'hA000 + 16'(k));
      poke16(32'h400 + 2 * k, 16'h0000);
      allow[0] = (k == 2);
      fire(4'b0001, 4'b0000);
      allow[0] = 1'b0;
      chk("R1 R2 word moved to buffer", 32'(peek16(32'h400 + 2 * k)), 32'hA000 + k);
      chk("R6 count written back", 32'(peek16(dp(0) + 4)), 2 - k);
      chk("R3 buffer advanced by 2", 32'(peek16(dp(0) + 6)), 32'h402 + 2 * k);
      chk("R4 I/O address fixed", 32'(peek16(dp(0) + 2)), 32'h100);
      chk("R6 irq only after last", 32'(irq_cnt[0]), (k == 2) ? 1 : 0);
    end
    chk("R6 status count end", 32'(status(0)), 1);
    chk("R6 mode bits kept", 32'(peek16(dp(0))), 32'h0019);

    // ch1: byte, buffer to I/O, both advance, count 2
    poke16(32'h440, 16'hC35A);
    poke16(32'h120, 16'h0000);
    poke16(32'h122, 16'h0000);
    set_desc(1, 16'h0007, 16'h0120, 16'd2, 16'h0440);
    fire(4'b0010, 4'b0000);
    allow[1] = 1'b1;
    fire(4'b0010, 4'b0000);
    allow[1] = 1'b0;
    chk("R2 byte mem2io first", 32'(peek16(32'h120)), 32'hC35A);
    chk("R2 byte only one lane", 32'(peek16(32'h122)), 32'h0000);
    chk("R4 I/O advanced by 1", 32'(peek16(dp(1) + 2)), 32'h122);
    chk("R3 buffer advanced by 1", 32'(peek16(dp(1) + 6)), 32'h442);
    chk("R6 ch1 status", 32'(status(1)), 1);
    chk("R6 ch1 irq", 32'(irq_cnt[1]), 1);

    // ch2: one transfer then terminate
    poke16(32'h140, 16'h1234);
    poke16(32'h482, 16'hEEEE);
    set_desc(2, 16'h0009, 16'h0140, 16'd5, 16'h0480);
    fire(4'b0100, 4'b0000);
    chk("R2 ch2 transfer", 32'(peek16(32'h480)), 32'h1234);
    poke16(32'h140, 16'h5678);
    allow[2] = 1'b1;
    fire(4'b0000, 4'b0100);
    allow[2] = 1'b0;
    chk("R5 no data after terminate", 32'(peek16(32'h482)), 32'hEEEE);
    chk("R5 count unchanged", 32'(peek16(dp(2) + 4)), 4);
    chk("R5 buffer unchanged", 32'(peek16(dp(2) + 6)), 32'h482);
    chk("R5 status terminated", 32'(status(2)), 2);
    chk("R5 irq on terminate", 32'(irq_cnt[2]), 1);

    // ch3: count zero at fetch
    poke16(32'h160, 16'h7777);
    poke16(32'h4C0, 16'h1111);
    set_desc(3, 16'h0009, 16'h0160, 16'd0, 16'h04C0);
    allow[3] = 1'b1;
    fire(4'b1000, 4'b0000);
    allow[3] = 1'b0;
    chk("R7 no transfer on zero count", 32'(peek16(32'h4C0)), 32'h1111);
    chk("R7 status count end", 32'(status(3)), 1);
    chk("R7 irq on zero count", 32'(irq_cnt[3]), 1);

    // ch0 disabled: bypass to irq
    set_desc(0, 16'h0009, 16'h0100, 16'd5, 16'h0500);
    poke16(32'h500, 16'h2222);
    svc_en[0] = 1'b0;
    allow[0] = 1'b1;
    fire(4'b0001, 4'b0000);
    allow[0] = 1'b0;
    svc_en[0] = 1'b1;
    chk("R8 bypass irq", 32'(irq_cnt[0]), 2);
    chk("R8 buffer untouched", 32'(peek16(32'h500)), 32'h2222);
    chk("R8 descriptor untouched", 32'(peek16(dp(0) + 4)), 5);

    // priority: ch3 and ch1 at once, each ending after one transfer
    set_desc(1, 16'h0009, 16'h0100, 16'd1, 16'h0540);
    set_desc(3, 16'h0009, 16'h0100, 16'd1, 16'h0560);
    base = order_q.size();
    allow[1] = 1'b1; allow[3] = 1'b1;
    fire(4'b1010, 4'b0000);
    allow[1] = 1'b0; allow[3] = 1'b0;
    chk("R9 two irqs", 32'(order_q.size() - base), 2);
    if (order_q.size() - base == 2) begin
      chk("R9 lower channel first", 32'(order_q[base]), 1);
      chk("R9 higher channel second", 32'(order_q[base + 1]), 3);
    end

    // ch2: both addresses fixed, count 2
    set_desc(2, 16'h0008, 16'h0140, 16'd2, 16'h0520);
    poke16(32'h140, 16'hBEEF);
    fire(4'b0100, 4'b0000);
    poke16(32'h140, 16'hCAFE);
    allow[2] = 1'b1;
    fire(4'b0100, 4'b0000);
    allow[2] = 1'b0;
    chk("R3 fixed buffer overwritten", 32'(peek16(32'h520)), 32'hCAFE);
    chk("R3 fixed buffer address", 32'(peek16(dp(2) + 6)), 32'h520);
    chk("R4 fixed I/O address", 32'(peek16(dp(2) + 2)), 32'h140);

    chk("R11 R6 monitor violations", 32'(mon_fail), 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule